// File: doc/BRIEF.md
# Nonvolatile Store and Recall Controller

This block sits between four active-low memory control pins (chip enable, output enable, write enable and nonvolatile enable) and a combined static-plus-nonvolatile memory array. It brings each pin into its own clock domain and classifies the pin pattern as one of five modes: read, write, store, recall or no operation. It then drives the array's read and write enables and the data-bus output enable. The array copies its volatile contents into nonvolatile cells on a store. It copies them back on a recall.

A store or recall is launched only when the pins enter the matching pattern. The pattern must then be held for a qualification window of `INIT_W` sampled clocks. After that, the cycle is committed and runs for a fixed number of clocks, and during that time every pin is ignored. A pattern that is still present when the cycle ends does not start a second cycle. A supply-valid input blocks stores while it is low and aborts a store that is running when it drops. When the supply becomes valid, a recall is forced.

The store cycle is long and the recall cycle is short. Both lengths are parameters, so real millisecond timing is reduced to clock counts.

Top module: `nvsr_ctrl`

## Requirements
- R1: The pin code chip enable 0, output enable 0, write enable 1, nonvolatile enable 1 is a read. While no cycle is busy, this code raises `rd_en` and `dq_oe` two clocks after the pins change, because of the two-stage synchroniser.
- R2: The code chip enable 0, write enable 0, nonvolatile enable 1 is a write, whatever the output enable is. While idle, it raises `wr_en` and keeps `dq_oe` low.
- R3: The code chip enable 0, write enable 0, nonvolatile enable 0, output enable 1 is a store request. A held request gives one `store_start` pulse and then `busy` for exactly `ST_CYC` clocks.
- R4: The code chip enable 0, output enable 0, nonvolatile enable 0, write enable 1 is a recall request. A held request gives one `recall_start` pulse and then `busy` for exactly `RC_CYC` clocks.
- R5: A request is committed only after its code has been seen on `INIT_W` consecutive sampled clocks, counting the entry clock. A request released earlier starts nothing.
- R6: A cycle starts only on entry into a request code. A code still present when a cycle ends starts nothing, and entries made while busy are ignored.
- R7: While `busy` is high, `rd_en`, `wr_en` and `dq_oe` are low. On the first idle clock, a read or write code present on the pins takes effect at once.
- R8: A store request that enters while the synchronised `supply_ok` is low starts nothing.
- R9: If `supply_ok` falls during a store, the store is abandoned and `busy` falls three clocks after the pin change.
- R10: A rising `supply_ok` forces a `recall_start` pulse and a recall of `RC_CYC` clocks, with no read or write granted during it.
- R11: During and right after reset, all outputs are low. The synchroniser starts from the idle pin code with the supply invalid.
- R12: Chip enable 1 in any combination, and the code with all four pins low, are no-operation codes: no enable and no cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable pin, active low |
| oe_n | input | 1 | Output enable pin, active low |
| we_n | input | 1 | Write enable pin, active low |
| nv_n | input | 1 | Nonvolatile enable pin, active low |
| supply_ok | input | 1 | High while the supply is above the safe threshold |
| store_start | output | 1 | One-clock pulse on the first clock of a store |
| recall_start | output | 1 | One-clock pulse on the first clock of a recall |
| busy | output | 1 | High while a store or recall runs |
| rd_en | output | 1 | Array read enable |
| wr_en | output | 1 | Array write enable |
| dq_oe | output | 1 | Data-bus output driver enable |

## Verification
Several rules are checked on every cycle by the assertions:
- the array enables and the bus driver stay quiet while busy;
- the two start pulses never coincide;
- a supply rise always yields a recall pulse on the next clock;
- a store never begins without a valid supply;
- a store seen with the supply invalid is abandoned on the next clock.

Other rules can only be shown by the bench scenarios, which compare all six outputs against a behavioural model on every clock:
- the exact store and recall lengths;
- the qualification window;
- the refusal to retrigger on a code that is held or re-entered while busy;
- a pending read taking effect the moment a cycle ends.

// File: rtl/nvsr_pkg.sv
package nvsr_pkg;

   typedef enum logic [2:0] {
      PM_NONE,
      PM_READ,
      PM_WRITE,
      PM_STORE,
      PM_RECALL
   } pin_mode_e;

   typedef enum logic [2:0] {
      SQ_IDLE,
      SQ_QUAL_ST,
      SQ_QUAL_RC,
      SQ_STORE,
      SQ_RECALL
   } seq_state_e;

endpackage

// File: rtl/nvsr_sync.sv
module nvsr_sync #(
   parameter int            W       = 5,
   parameter int            STAGES  = 2,
   parameter logic [W-1:0]  RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("nvsr_sync: STAGES must be at least 2");
      end
      if (W < 1) begin : g_bad_width
         $error("nvsr_sync: W must be at least 1");
      end
   endgenerate

   logic [STAGES-1:0][W-1:0] stg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg <= {STAGES{RST_VAL}};
      else        stg <= {stg[STAGES-2:0], d};
   end

   assign q = stg[STAGES-1];

endmodule

// File: rtl/nvsr_decode.sv
module nvsr_decode
   import nvsr_pkg::*;
(
   input  logic      ce_n,
   input  logic      oe_n,
   input  logic      we_n,
   input  logic      nv_n,
   output pin_mode_e mode
);

   always_comb begin
      mode = PM_NONE;
      if (!ce_n) begin
         if (nv_n) begin
            if (!we_n)     mode = PM_WRITE;
            else if (!oe_n) mode = PM_READ;
         end else begin
            if (!we_n && oe_n)      mode = PM_STORE;
            else if (we_n && !oe_n) mode = PM_RECALL;
         end
      end
   end

endmodule

// File: rtl/nvsr_seq.sv
module nvsr_seq
   import nvsr_pkg::*;
#(
   parameter int INIT_W = 4,
   parameter int ST_CYC = 512,
   parameter int RC_CYC = 40
) (
   input  logic      clk,
   input  logic      rst_n,
   input  pin_mode_e mode,
   input  logic      sup,
   output logic      busy,
   output logic      store_start,
   output logic      recall_start
);

   localparam int CNT_MAX = (ST_CYC > RC_CYC) ? ST_CYC : RC_CYC;
   localparam int CW      = $clog2(CNT_MAX);
   localparam int QW      = $clog2(INIT_W);

   generate
      if (INIT_W < 2) begin : g_bad_init
         $error("nvsr_seq: INIT_W must be at least 2");
      end
      if (ST_CYC < 2 || RC_CYC < 2) begin : g_bad_len
         $error("nvsr_seq: cycle lengths must be at least 2");
      end
   endgenerate

   seq_state_e     state, st_n;
   logic [CW-1:0]  cnt, cnt_n;
   logic [QW-1:0]  qcnt, q_n;
   pin_mode_e      mode_q;
   logic           sup_q;
   logic           ss_q, rs_q, ss_n, rs_n;

   always_comb begin
      st_n  = state;
      cnt_n = cnt;
      q_n   = qcnt;
      ss_n  = 1'b0;
      rs_n  = 1'b0;
      if (sup && !sup_q) begin
         st_n  = SQ_RECALL;
         cnt_n = CW'(RC_CYC - 1);
         rs_n  = 1'b1;
      end else begin
         case (state)
            SQ_IDLE: begin
               if (mode == PM_STORE && mode_q != PM_STORE && sup) begin
                  st_n = SQ_QUAL_ST;
                  q_n  = QW'(1);
               end else if (mode == PM_RECALL && mode_q != PM_RECALL) begin
                  st_n = SQ_QUAL_RC;
                  q_n  = QW'(1);
               end
            end
            SQ_QUAL_ST: begin
               if (mode != PM_STORE || !sup) begin
                  st_n = SQ_IDLE;
               end else if (qcnt == QW'(INIT_W - 1)) begin
                  st_n  = SQ_STORE;
                  cnt_n = CW'(ST_CYC - 1);
                  ss_n  = 1'b1;
               end else begin
                  q_n = qcnt + QW'(1);
               end
            end
            SQ_QUAL_RC: begin
               if (mode != PM_RECALL) begin
                  st_n = SQ_IDLE;
               end else if (qcnt == QW'(INIT_W - 1)) begin
                  st_n  = SQ_RECALL;
                  cnt_n = CW'(RC_CYC - 1);
                  rs_n  = 1'b1;
               end else begin
                  q_n = qcnt + QW'(1);
               end
            end
            SQ_STORE: begin
               if (!sup)                st_n = SQ_IDLE;
               else if (cnt == '0)      st_n = SQ_IDLE;
               else                     cnt_n = cnt - CW'(1);
            end
            SQ_RECALL: begin
               if (cnt == '0) st_n = SQ_IDLE;
               else           cnt_n = cnt - CW'(1);
            end
            default: st_n = SQ_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= SQ_IDLE;
         cnt    <= '0;
         qcnt   <= '0;
         mode_q <= PM_NONE;
         sup_q  <= 1'b0;
         ss_q   <= 1'b0;
         rs_q   <= 1'b0;
      end else begin
         state  <= st_n;
         cnt    <= cnt_n;
         qcnt   <= q_n;
         mode_q <= mode;
         sup_q  <= sup;
         ss_q   <= ss_n;
         rs_q   <= rs_n;
      end
   end

   assign busy         = (state == SQ_STORE) || (state == SQ_RECALL);
   assign store_start  = ss_q;
   assign recall_start = rs_q;

   // R9: a store observed with an invalid supply is abandoned next clock
   a_r9_store_abort: assert property (@(posedge clk) disable iff (!rst_n)
      (state == SQ_STORE && !sup) |=> (state == SQ_IDLE));

   // R10: a supply rise forces a recall pulse
   a_r10_auto_recall: assert property (@(posedge clk) disable iff (!rst_n)
      (sup && !sup_q) |=> recall_start);

   // R8: a store never begins without a valid supply
   a_r8_store_inhibit: assert property (@(posedge clk) disable iff (!rst_n)
      store_start |-> $past(sup));

   // R3 and R4: at most one kind of cycle starts at a time
   a_r3_one_start: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({store_start, recall_start}));

   // R4: a recall pulse is always accompanied by busy
   a_r4_recall_busy: assert property (@(posedge clk) disable iff (!rst_n)
      recall_start |-> busy);

endmodule

// File: rtl/nvsr_ctrl.sv
module nvsr_ctrl
   import nvsr_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int INIT_W      = 4,
   parameter int ST_CYC      = 512,
   parameter int RC_CYC      = 40
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ce_n,
   input  logic oe_n,
   input  logic we_n,
   input  logic nv_n,
   input  logic supply_ok,
   output logic store_start,
   output logic recall_start,
   output logic busy,
   output logic rd_en,
   output logic wr_en,
   output logic dq_oe
);

   localparam int PINS = 5;
   localparam logic [PINS-1:0] PIN_IDLE = 5'b01111;

   logic [PINS-1:0] raw, syn;
   pin_mode_e       mode;

   assign raw = {supply_ok, nv_n, we_n, oe_n, ce_n};

   nvsr_sync #(.W(PINS), .STAGES(SYNC_STAGES), .RST_VAL(PIN_IDLE)) sync_i (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (raw),
      .q     (syn)
   );

   nvsr_decode dec_i (
      .ce_n (syn[0]),
      .oe_n (syn[1]),
      .we_n (syn[2]),
      .nv_n (syn[3]),
      .mode (mode)
   );

   nvsr_seq #(.INIT_W(INIT_W), .ST_CYC(ST_CYC), .RC_CYC(RC_CYC)) seq_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .mode         (mode),
      .sup          (syn[4]),
      .busy         (busy),
      .store_start  (store_start),
      .recall_start (recall_start)
   );

   assign rd_en = !busy && (mode == PM_READ);
   assign wr_en = !busy && (mode == PM_WRITE);
   assign dq_oe = rd_en;

   // R7: nothing reaches the array or the bus while a cycle runs
   a_r7_busy_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !(rd_en || wr_en || dq_oe));

   // R2: the bus driver is never on during a write
   a_r2_no_drive_on_write: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> !dq_oe);

   // R3: a store pulse comes only from a store code with the chip enabled
   a_r3_store_from_code: assert property (@(posedge clk) disable iff (!rst_n)
      store_start |-> $past(mode == PM_STORE));

endmodule

// File: tb/nvsr_ctrl_tb.sv
module nvsr_ctrl_tb_top;

   localparam int INIT_W = 4;
   localparam int ST_CYC = 512;
   localparam int RC_CYC = 40;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, nv_n = 1'b1, supply_ok = 1'b0;
   logic store_start, recall_start, busy, rd_en, wr_en, dq_oe;

   always #2 clk = ~clk;

   nvsr_ctrl #(.SYNC_STAGES(2), .INIT_W(INIT_W), .ST_CYC(ST_CYC), .RC_CYC(RC_CYC)) dut_i (
      .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n), .nv_n(nv_n),
      .supply_ok(supply_ok), .store_start(store_start), .recall_start(recall_start),
      .busy(busy), .rd_en(rd_en), .wr_en(wr_en), .dq_oe(dq_oe));

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;
   string tag = "R11";
   int n_st = 0;
   int n_rc = 0;

   // behavioural model: pin history, mode of each sample, sequencer state
   bit [4:0] h_a = 5'b01111, h_b = 5'b01111, h_c = 5'b01111;
   int  ms = 0;
   int  mcnt = 0;
   int  mq = 0;
   bit  e_ss = 0, e_rs = 0;

   function automatic int md(bit [4:0] p);
      if (p[0]) return 0;
      if (p[3]) begin
         if (!p[2]) return 2;
         if (!p[1]) return 1;
         return 0;
      end
      if (!p[2] && p[1]) return 3;
      if (p[2] && !p[1]) return 4;
      return 0;
   endfunction

   task automatic model_step();
      int m, mp;
      bit s, sp;
      m = md(h_b); mp = md(h_c); s = h_b[4]; sp = h_c[4];
      e_ss = 0; e_rs = 0;
      if (s && !sp) begin
         ms = 4; mcnt = RC_CYC; e_rs = 1;
      end else begin
         case (ms)
            0: if (m == 3 && mp != 3 && s) begin ms = 1; mq = 1; end
               else if (m == 4 && mp != 4) begin ms = 2; mq = 1; end
            1: if (m != 3 || !s) ms = 0;
               else begin
                  mq++;
                  if (mq == INIT_W) begin ms = 3; mcnt = ST_CYC; e_ss = 1; end
               end
            2: if (m != 4) ms = 0;
               else begin
                  mq++;
                  if (mq == INIT_W) begin ms = 4; mcnt = RC_CYC; e_rs = 1; end
               end
            3: if (!s) ms = 0;
               else begin mcnt--; if (mcnt == 0) ms = 0; end
            4: begin mcnt--; if (mcnt == 0) ms = 0; end
            default: ms = 0;
         endcase
      end
      h_c = h_b; h_b = h_a;
      h_a = {supply_ok, nv_n, we_n, oe_n, ce_n};
   endtask

   task automatic chk(string req, string name, logic act, logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%0b expected=%0b", req, name, act, exp);
      end
   endtask

   task automatic compare_all();
      bit eb, er, ew;
      eb = (ms >= 3);
      er = !eb && md(h_b) == 1;
      ew = !eb && md(h_b) == 2;
      chk(tag, "busy", busy, eb);
      chk(tag, "rd_en", rd_en, er);
      chk(tag, "wr_en", wr_en, ew);
      chk(tag, "dq_oe", dq_oe, er);
      chk(tag, "store_start", store_start, e_ss);
      chk(tag, "recall_start", recall_start, e_rs);
      if (store_start === 1'b1) n_st++;
      if (recall_start === 1'b1) n_rc++;
   endtask

   task automatic tick(int n);
      for (int i = 0; i < n; i++) begin
         @(posedge clk);
         #1 model_step();
         @(negedge clk);
         compare_all();
      end
   endtask

   task automatic pins(bit ce, bit oe, bit we, bit nv);
      ce_n = ce; oe_n = oe; we_n = we; nv_n = nv;
   endtask

   task automatic count_chk(string req, int st_exp, int rc_exp);
      checks++;
      if (n_st != st_exp) begin
         errors++;
         $display("FAIL %s store pulses actual=%0d expected=%0d", req, n_st, st_exp);
      end
      checks++;
      if (n_rc != rc_exp) begin
         errors++;
         $display("FAIL %s recall pulses actual=%0d expected=%0d", req, n_rc, rc_exp);
      end
      n_st = 0; n_rc = 0;
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++; checks++;
         $display("FAIL R11 watchdog actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin : main
      repeat (3) @(negedge clk);
      tag = "R11";
      compare_all();
      rst_n = 1'b1;
      tick(3);
      count_chk("R11", 0, 0);

      // R10: supply comes up with a read pending; read waits for recall
      tag = "R10";
      supply_ok = 1'b1;
      pins(0, 0, 1, 1);
      tick(RC_CYC + 8);
      count_chk("R10", 0, 1);

      tag = "R1";  pins(0, 0, 1, 1); tick(5);
      checks++;
      if (rd_en !== 1'b1 || dq_oe !== 1'b1) begin
         errors++;
         $display("FAIL R1 read grant actual=%0b%0b expected=11", rd_en, dq_oe);
      end
      tag = "R2";  pins(0, 1, 0, 1); tick(5);
      pins(0, 0, 0, 1); tick(4);
      tag = "R12"; pins(0, 0, 0, 0); tick(6);
      pins(1, 1, 0, 0); tick(6);
      pins(1, 0, 1, 0); tick(6);
      pins(1, 1, 1, 1); tick(4);
      count_chk("R12", 0, 0);

      // R5: store code released before the window closes
      tag = "R5";
      pins(0, 1, 0, 0); tick(INIT_W - 2);
      pins(1, 1, 1, 1); tick(6);
      pins(0, 0, 1, 0); tick(INIT_W - 1);
      pins(1, 1, 1, 1); tick(6);
      count_chk("R5", 0, 0);

      // R3 then R6: held store code, kept after completion
      tag = "R3";
      pins(0, 1, 0, 0); tick(ST_CYC + 20);
      tag = "R6"; tick(12);
      pins(1, 1, 1, 1); tick(5);
      count_chk("R3", 1, 0);

      // R7: read pending when the store ends takes effect immediately
      tag = "R7";
      pins(0, 1, 0, 0); tick(INIT_W + 3);
      pins(0, 0, 1, 1); tick(ST_CYC + 6);
      checks++;
      if (rd_en !== 1'b1 || busy !== 1'b0) begin
         errors++;
         $display("FAIL R7 read after store actual=%0b%0b expected=10", rd_en, busy);
      end
      pins(1, 1, 1, 1); tick(4);
      count_chk("R7", 1, 0);

      // R4 then R6: recall, store code entered while busy is ignored
      tag = "R4";
      pins(0, 0, 1, 0); tick(INIT_W + 5);
      tag = "R6";
      pins(0, 1, 0, 0); tick(RC_CYC + 15);
      pins(1, 1, 1, 1); tick(5);
      count_chk("R6", 0, 1);

      // R8: store request with the supply invalid
      tag = "R8";
      supply_ok = 1'b0; tick(4);
      pins(0, 1, 0, 0); tick(INIT_W + 10);
      checks++;
      if (busy !== 1'b0) begin
         errors++;
         $display("FAIL R8 busy actual=%0b expected=0", busy);
      end
      pins(1, 1, 1, 1); tick(3);
      tag = "R10"; supply_ok = 1'b1; tick(RC_CYC + 8);
      count_chk("R8", 0, 1);

      // R9: supply lost during a store
      tag = "R9";
      pins(0, 1, 0, 0); tick(INIT_W + 20);
      supply_ok = 1'b0; tick(3);
      checks++;
      if (busy !== 1'b0) begin
         errors++;
         $display("FAIL R9 busy after drop actual=%0b expected=0", busy);
      end
      pins(1, 1, 1, 1); tick(4);
      supply_ok = 1'b1; tick(RC_CYC + 8);
      count_chk("R9", 1, 1);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule